// File: doc/BRIEF.md
# I/O-Mapped Converter Card Bus Decoder

This block sits between a 16-bit I/O host bus and two external eight-channel converter groups. It compares the upper twelve address lines against a base address set by static jumper inputs. A fitted jumper pulls its address bit to 0 and an open one leaves it at 1, so the card can be placed on any 16-byte boundary. Within the card's 16-byte window, the low four address bits select an access.

Each group has two offsets. The even offset takes a control-byte write and returns the low result byte on a read. The odd offset returns the high result nibble. One shared offset returns both groups' busy flags. Reads of any other offset, and accesses outside the window, leave the data bus undriven.

Each group has a pending-interrupt flag. The flag sets when the group's busy line falls and clears on the next control write to that group. The two flags are combined into one request. The request is driven either as a plain level or, in shared-line mode, with the output driver enabled only while the request is active.

Top module: `io_card_decoder`

## Requirements
- R1: The card is selected when bus_addr[15:4] equals the bitwise inverse of jmp_fitted[11:0]; any other value of those bits selects nothing.
- R2: A write strobe at offset 0 (group 0) or offset 2 (group 1) produces a one-cycle pulse on that group's bit of grp_ctl_we one clock later, with grp_ctl_byte holding the written byte; at most one bit pulses.
- R3: A read strobe at offset 0 or 2 returns result bits 7..0 of group 0 or group 1, and offset 1 or 3 returns {4'b0, result bits 11..8}, on bus_rdata with bus_rdata_oe high, one clock after the strobe.
- R4: A read strobe at offset 8 returns {6'b0, busy of group 1, busy of group 0}, where 0 means conversion complete, one clock after the strobe.
- R5: A read of a selected card at an offset other than 0, 1, 2, 3 or 8, or a read that misses the base, gives bus_rdata_oe low and bus_rdata 0. A write at a non-control offset or a missed base gives no grp_ctl_we pulse.
- R6: A group's interrupt pending flag sets at the clock edge that first samples its busy input low after it was high.
- R7: A control write to a group clears that group's pending flag at the edge that samples the write strobe, and the clear wins over a completion event in the same cycle.
- R8: The interrupt request is the OR of both groups' pending flags and appears on irq_out.
- R9: With irq_share low, irq_oe is held high. With irq_share high, irq_oe is high only while the request is active.
- R10: After reset, bus_rdata_oe, grp_ctl_we and irq_out are low and both pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_fitted | input | 12 | Jumper state for address bits 15..4, 1 = fitted (bit reads 0) |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rdata_oe | output | 1 | Read data driver enable |
| grp_busy | input | 2 | Busy flag per converter group |
| grp_result | input | 24 | 12-bit result per group, group 0 in the low bits |
| grp_ctl_we | output | 2 | Control write pulse per group |
| grp_ctl_byte | output | 8 | Control byte for the pulsed group |
| irq_share | input | 1 | 1 = shared-line interrupt drive |
| irq_out | output | 1 | Composite interrupt request level |
| irq_oe | output | 1 | Interrupt driver enable |

## Verification
Reads and control writes each pass through one register stage. Read data, the read enable and the control pulse are therefore due in the clock cycle after the one whose edge samples the strobe. The interrupt level follows the first edge that samples busy low or samples a control write. A scoreboard queue holds the expected value for each read strobe. A monitor sampling on the falling edge pops one entry in the cycle after each strobe. Write and interrupt checks are taken on the falling edge one cycle after the stimulus edge, so every sample falls midway between the edge that updates the result and the next one.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  // What a decoded read offset returns
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_GRP  = 2'd1,
    SRC_STAT = 2'd2
  } rd_src_e;
endpackage

// File: rtl/io_addr_match.sv
module io_addr_match #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  localparam int SEL_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SEL_W-1:0]  jmp_fitted,
  output logic              hit,
  output logic [OFF_W-1:0]  offset
);
  // A fitted jumper pulls its bit to zero
  function automatic logic [SEL_W-1:0] base_of(input logic [SEL_W-1:0] fitted);
    return ~fitted;
  endfunction

  assign hit    = (bus_addr[ADDR_W-1:OFF_W] == base_of(jmp_fitted));
  assign offset = bus_addr[OFF_W-1:0];
endmodule

// File: rtl/io_grp_port.sv
module io_grp_port #(
  parameter int OFF_W   = 4,
  parameter int RES_W   = 12,
  parameter int DATA_W  = 8,
  parameter int GRP_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [OFF_W-1:0]  offset,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              busy,
  input  logic [RES_W-1:0]  result,
  output logic              ctl_we,
  output logic              pend,
  output logic              rd_sel,
  output logic [DATA_W-1:0] rd_byte,
  output logic              done_evt,
  output logic              wr_hit
);
  localparam logic [OFF_W-1:0] LO_OFF = OFF_W'(2 * GRP_IDX);
  localparam logic [OFF_W-1:0] HI_OFF = OFF_W'(2 * GRP_IDX + 1);

  function automatic logic [DATA_W-1:0] low_part(input logic [RES_W-1:0] r);
    return DATA_W'(r);
  endfunction

  function automatic logic [DATA_W-1:0] high_part(input logic [RES_W-1:0] r);
    return DATA_W'(r >> DATA_W);
  endfunction

  logic sel_lo, sel_hi, busy_q;

  assign sel_lo   = hit && (offset == LO_OFF);
  assign sel_hi   = hit && (offset == HI_OFF);
  assign wr_hit   = bus_wr && sel_lo;
  assign rd_sel   = bus_rd && (sel_lo || sel_hi);
  assign rd_byte  = sel_hi ? high_part(result) : low_part(result);
  assign done_evt = busy_q && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend   <= 1'b0;
      ctl_we <= 1'b0;
    end else begin
      busy_q <= busy;
      pend   <= (pend || done_evt) && !wr_hit;
      ctl_we <= wr_hit;
    end
  end

  // R6: a completion with no write in the same cycle leaves the flag set
  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !wr_hit) |=> pend);
  // R7: a control write always clears, even against a completion
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> !pend);
  // R2: the control pulse follows its write by one cycle
  a_r2_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ctl_we);
endmodule

// File: rtl/io_irq_drive.sv
module io_irq_drive #(
  parameter int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUPS-1:0] pend,
  input  logic              irq_share,
  output logic              irq_out,
  output logic              irq_oe
);
  logic req;
  assign req     = |pend;
  assign irq_out = req;
  assign irq_oe  = irq_share ? req : 1'b1;

  // R9: in shared mode the line is released whenever no flag is pending
  a_r9_shared_release: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_share && pend == '0) |-> !irq_oe);
  // R9: direct mode always drives
  a_r9_direct_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_share |-> irq_oe);
endmodule

// File: rtl/io_card_decoder.sv
module io_card_decoder #(
  parameter int ADDR_W   = 16,
  parameter int OFF_W    = 4,
  parameter int GROUPS   = 2,
  parameter int RES_W    = 12,
  parameter int DATA_W   = 8,
  parameter int STAT_OFF = 8,
  localparam int SEL_W   = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        jmp_fitted,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_rdata_oe,
  input  logic [GROUPS-1:0]       grp_busy,
  input  logic [GROUPS*RES_W-1:0] grp_result,
  output logic [GROUPS-1:0]       grp_ctl_we,
  output logic [DATA_W-1:0]       grp_ctl_byte,
  input  logic                    irq_share,
  output logic                    irq_out,
  output logic                    irq_oe
);
  import io_dec_pkg::*;

  localparam logic [OFF_W-1:0] STAT_SLOT = OFF_W'(STAT_OFF);

  logic                   hit;
  logic [OFF_W-1:0]       offset;
  logic [GROUPS-1:0]      pend, rd_sel, done_evt, wr_hit;
  logic [DATA_W-1:0]      rd_byte [GROUPS];
  logic [DATA_W-1:0]      grp_byte;
  rd_src_e                src;
  logic [DATA_W-1:0]      rd_next;

  io_addr_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .bus_addr   (bus_addr),
    .jmp_fitted (jmp_fitted),
    .hit        (hit),
    .offset     (offset)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    io_grp_port #(.OFF_W(OFF_W), .RES_W(RES_W), .DATA_W(DATA_W), .GRP_IDX(g)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .offset   (offset),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .busy     (grp_busy[g]),
      .result   (grp_result[g*RES_W +: RES_W]),
      .ctl_we   (grp_ctl_we[g]),
      .pend     (pend[g]),
      .rd_sel   (rd_sel[g]),
      .rd_byte  (rd_byte[g]),
      .done_evt (done_evt[g]),
      .wr_hit   (wr_hit[g])
    );
  end

  // Pick the read source for this strobe
  always_comb begin
    grp_byte = '0;
    for (int g = 0; g < GROUPS; g++)
      if (rd_sel[g]) grp_byte = rd_byte[g];
    if (|rd_sel)
      src = SRC_GRP;
    else if (bus_rd && hit && offset == STAT_SLOT)
      src = SRC_STAT;
    else
      src = SRC_NONE;
    case (src)
      SRC_GRP:  rd_next = grp_byte;
      SRC_STAT: rd_next = DATA_W'(grp_busy);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_rdata_oe <= 1'b0;
      grp_ctl_byte <= '0;
    end else begin
      bus_rdata    <= rd_next;
      bus_rdata_oe <= (src != SRC_NONE);
      if (|wr_hit) grp_ctl_byte <= bus_wdata;
    end
  end

  io_irq_drive #(.GROUPS(GROUPS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .irq_share (irq_share),
    .irq_out   (irq_out),
    .irq_oe    (irq_oe)
  );

  // R2: never two groups at once, and only after a write strobe
  a_r2_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_ctl_we));
  a_r2_we_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_ctl_we) |-> $past(bus_wr));
  // R5: the read driver only follows a read strobe, and never a missed base
  a_r5_oe_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> $past(bus_rd));
  a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> !bus_rdata_oe);
  // R8: a completion on any group raises the composite request
  a_r8_any_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_evt & ~wr_hit)) |=> irq_out);
endmodule

// File: tb/tb_io_card_decoder.sv
`timescale 1ns/1ps
module tb_io_card_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] jmp_fitted = ~12'h7FF;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_oe;
  logic [1:0]  grp_busy = 2'b00;
  logic [23:0] grp_result = {12'h3E7, 12'hA5C};
  logic [1:0]  grp_ctl_we;
  logic [7:0]  grp_ctl_byte;
  logic        irq_share = 1'b0;
  logic        irq_out, irq_oe;

  always #2 clk = ~clk;

  io_card_decoder dut (
    .clk(clk), .rst_n(rst_n), .jmp_fitted(jmp_fitted), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .grp_busy(grp_busy), .grp_result(grp_result),
    .grp_ctl_we(grp_ctl_we), .grp_ctl_byte(grp_ctl_byte),
    .irq_share(irq_share), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic       oe;
    logic [7:0] data;
    string      tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  // Monitor: one cycle after each read strobe, compare with the scoreboard
  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", 1, 0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk({it.tag, " oe"}, bus_rdata_oe, it.oe);
        chk({it.tag, " data"}, bus_rdata, it.oe ? it.data : 8'h00);
      end
    end
  end

  task automatic do_read(logic [15:0] a, logic oe, logic [7:0] d, string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    it.oe = oe; it.data = d; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d, logic [1:0] exp_we, string tag);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk({tag, " we"}, grp_ctl_we, exp_we);
    if (exp_we != 2'b00) chk({tag, " byte"}, grp_ctl_byte, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 rdata_oe", bus_rdata_oe, 0);
    chk("R10 ctl_we", grp_ctl_we, 0);
    chk("R10 irq_out", irq_out, 0);
    chk("R9 direct oe after reset", irq_oe, 1);

    // R3: result bytes at base 7FF0
    do_read(16'h7FF0, 1, 8'h5C, "R3 grp0 lo");
    do_read(16'h7FF1, 1, 8'h0A, "R3 grp0 hi");
    do_read(16'h7FF2, 1, 8'hE7, "R3 grp1 lo");
    do_read(16'h7FF3, 1, 8'h03, "R3 grp1 hi");

    // R4: status byte
    grp_busy = 2'b10;
    do_read(16'h7FF8, 1, 8'h02, "R4 status busy1");
    grp_busy = 2'b01;
    do_read(16'h7FF8, 1, 8'h01, "R4 status busy0");
    grp_busy = 2'b00;

    // R5: undecoded offsets and missed base
    do_read(16'h7FF4, 0, 8'h00, "R5 offset 4");
    do_read(16'h7FFF, 0, 8'h00, "R5 offset F");
    do_read(16'h7FE0, 0, 8'h00, "R5 base miss");

    // R1: new jumper setting, base 3040
    jmp_fitted = ~12'h304;
    do_read(16'h3042, 1, 8'hE7, "R1 new base hit");
    do_read(16'h7FF2, 0, 8'h00, "R1 old base miss");
    grp_result = {12'hF01, 12'h7B2};
    do_read(16'h3041, 1, 8'h07, "R1 R3 grp0 hi new data");
    do_read(16'h3042, 1, 8'h01, "R3 grp1 lo new data");
    @(negedge clk);

    // R2: control writes (also clear flags from the status test)
    do_write(16'h3040, 8'h40, 2'b01, "R2 grp0 ctl");
    do_write(16'h3042, 8'h58, 2'b10, "R2 grp1 ctl");
    do_write(16'h3041, 8'h11, 2'b00, "R5 write offset 1");
    do_write(16'h3048, 8'h22, 2'b00, "R5 write status offset");
    do_write(16'h7FF0, 8'h33, 2'b00, "R5 write base miss");
    chk("R7 flags clear after writes", irq_out, 0);

    // R6, R8: direct mode completions
    @(negedge clk); grp_busy = 2'b11;
    @(negedge clk); grp_busy = 2'b01;
    @(negedge clk);
    chk("R6 grp1 done raises irq", irq_out, 1);
    chk("R9 direct oe", irq_oe, 1);
    grp_busy = 2'b00;
    @(negedge clk);
    do_write(16'h3042, 8'h58, 2'b10, "R7 clear grp1");
    chk("R8 grp0 still pending", irq_out, 1);
    do_write(16'h3040, 8'h40, 2'b01, "R7 clear grp0");
    chk("R7 all clear", irq_out, 0);

    // R9: shared-line mode
    irq_share = 1'b1;
    @(negedge clk);
    chk("R9 shared released", irq_oe, 0);
    grp_busy = 2'b10;
    @(negedge clk); grp_busy = 2'b00;
    @(negedge clk);
    chk("R9 shared drives", irq_oe, 1);
    chk("R8 shared level", irq_out, 1);
    do_write(16'h3042, 8'h5A, 2'b10, "R7 shared clear");
    chk("R9 shared released again", irq_oe, 0);

    // R7: write and completion in the same cycle
    irq_share = 1'b0;
    grp_busy = 2'b10;
    @(negedge clk);
    bus_addr = 16'h3042; bus_wdata = 8'h5C; bus_wr = 1'b1;
    grp_busy = 2'b00;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R7 same-cycle we", grp_ctl_we, 2'b10);
    chk("R7 write wins", irq_out, 0);
    @(negedge clk);
    chk("R7 stays clear", irq_out, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule